// File: doc/BRIEF.md
# Multi-Word Flash Program Sequencer

This block writes up to four 32-bit words into flash in response to a single start pulse. Software fills any of four word buffers. Each buffer has a pending bit that is set on a write. A start pulse then carries the base address. The sequencer walks the buffers in ascending order and issues one single-word program request per pending buffer over a request/acknowledge port. Word n goes to base + 4*n. Each pending bit is cleared once its word is accepted.

Status outputs give a busy flag, a flag that is high while a word request is outstanding, the address of the word being programmed, and a sticky fail flag. The address output keeps its last value after the run ends. Buffer 0 also serves as the data register of the single-word program path, so both paths always see the same value. The fail flag is set by a verify mismatch reported on the flash port, or by a start whose base address is not 8-byte aligned. A run that fails leaves the unprogrammed words pending, so software can restart the run after it clears the fail flag.

Top module: `mwprog_seq`

## Requirements
- R1: After reset, busy, in_prog, fl_req and fail are 0, pend is 0000 and prog_addr is 0.
- R2: A write with wr_en while idle stores wr_data in buffer wr_sel (0 to 3), which can then be read on rd_data with rd_sel. It also sets pend bit wr_sel.
- R3: sw_data always equals buffer 0.
- R4: A start while idle with start_addr[2:0] == 000 raises busy from the next cycle. Busy falls by itself when the run ends.
- R5: Pending buffers are programmed in ascending index order, buffer n at start_addr + 4*n. A buffer whose pend bit is clear produces no request.
- R6: fl_req stays high, with fl_addr and fl_data stable, until fl_ack. in_prog is high exactly while fl_req is high.
- R7: An fl_ack without fl_err clears the pend bit of the buffer being programmed.
- R8: During a run, prog_addr shows the address of the current buffer. After the run it keeps the last address reached, which is start_addr when nothing was pending.
- R9: An fl_ack with fl_err ends the run. Fail is set, busy clears, and the failing buffer and all later pend bits stay set.
- R10: A start while idle with start_addr[2:0] != 000 sets fail and starts no run.
- R11: While busy, wr_en and start have no effect on the buffers, the pend bits or the run.
- R12: fail_clr clears fail. A fail event in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_sel | input | 2 | Buffer index for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Buffer index for read-back |
| rd_data | output | 32 | Contents of the selected buffer |
| sw_data | output | 32 | Buffer 0, shared with the single-word path |
| start | input | 1 | Start pulse |
| start_addr | input | 32 | Base flash address of the run |
| fail_clr | input | 1 | Clears the fail flag |
| busy | output | 1 | Run active |
| in_prog | output | 1 | A word request is outstanding |
| pend | output | 4 | Per-buffer pending bits |
| prog_addr | output | 32 | Address of the current or last word |
| fail | output | 1 | Sticky fail flag |
| fl_req | output | 1 | Single-word program request |
| fl_addr | output | 32 | Program address |
| fl_data | output | 32 | Program data |
| fl_ack | input | 1 | Request accepted |
| fl_err | input | 1 | Verify mismatch, valid with fl_ack |

## Verification
The hardest case to reach is a verify mismatch in the middle of a run, followed by a restart. In that case the pend bits must keep exactly the unprogrammed tail, and the second run must resume at the right address. The bench flash responder raises fl_err when it sees one chosen address. A four-word run is then made to fail on its second word. Fail is cleared and the run is restarted from the same base. The responder latency is also varied, and writes and starts are issued while busy, so that held requests and ignored inputs land on real request cycles.

// File: rtl/mwprog_pkg.sv
package mwprog_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_SCAN = 2'd1,
    SEQ_REQ  = 2'd2
  } seq_st_e;
endpackage

// File: rtl/mwprog_rst_sync.sv
module mwprog_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;
endmodule

// File: rtl/mwprog_regs.sv
module mwprog_regs #(
  parameter int NWORDS = 4,
  parameter int DW     = 32,
  localparam int IW    = $clog2(NWORDS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IW-1:0]              wr_sel,
  input  logic [DW-1:0]              wr_data,
  input  logic                       lock,
  input  logic [NWORDS-1:0]          clr_vec,
  output logic [NWORDS-1:0][DW-1:0]  words_o,
  output logic [NWORDS-1:0]          pend_o
);
  logic [NWORDS-1:0] word_we;
  logic [NWORDS-1:0] pend_d;
  logic [NWORDS-1:0] pend_q;

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    logic [DW-1:0] word_q;

    always_comb begin
      word_we[i] = wr_en && !lock && (wr_sel == IW'(i));
      pend_d[i]  = word_we[i] || (pend_q[i] && !clr_vec[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_we[i]) begin
        word_q <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
      end else begin
        pend_q[i] <= pend_d[i];
      end
    end

    assign words_o[i] = word_q;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/mwprog_fsm.sv
module mwprog_fsm
  import mwprog_pkg::*;
#(
  parameter int NWORDS = 4,
  parameter int AW     = 32,
  parameter int ALIGN  = 3,
  localparam int IW    = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  input  logic              fail_clr,
  input  logic [NWORDS-1:0] pend,
  input  logic              fl_ack,
  input  logic              fl_err,
  output logic              busy,
  output logic              in_prog,
  output logic [IW-1:0]     idx_o,
  output logic [AW-1:0]     addr_o,
  output logic [NWORDS-1:0] clr_vec,
  output logic              fail_o
);
  localparam logic [IW-1:0] LAST_IDX   = IW'(NWORDS - 1);
  localparam logic [AW-1:0] ALIGN_MASK = AW'((64'd1 << ALIGN) - 64'd1);

  seq_st_e       st_q, st_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [AW-1:0] base_q, base_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          fail_q, fail_d;
  logic          fail_set;
  logic          aligned;

  assign aligned = (start_addr & ALIGN_MASK) == '0;

  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    base_d   = base_q;
    addr_d   = addr_q;
    clr_vec  = '0;
    fail_set = 1'b0;
    unique case (st_q)
      SEQ_IDLE: begin
        if (start) begin
          if (aligned) begin
            st_d   = SEQ_SCAN;
            idx_d  = '0;
            base_d = start_addr;
            addr_d = start_addr;
          end else begin
            fail_set = 1'b1;
          end
        end
      end
      SEQ_SCAN: begin
        if (pend[idx_q]) begin
          st_d   = SEQ_REQ;
          addr_d = base_q + AW'({idx_q, 2'b00});
        end else if (idx_q == LAST_IDX) begin
          st_d = SEQ_IDLE;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      SEQ_REQ: begin
        if (fl_ack) begin
          if (fl_err) begin
            fail_set = 1'b1;
            st_d     = SEQ_IDLE;
          end else begin
            clr_vec[idx_q] = 1'b1;
            if (idx_q == LAST_IDX) begin
              st_d = SEQ_IDLE;
            end else begin
              idx_d = idx_q + 1'b1;
              st_d  = SEQ_SCAN;
            end
          end
        end
      end
      default: st_d = SEQ_IDLE;
    endcase

    if (fail_set) begin
      fail_d = 1'b1;
    end else if (fail_clr) begin
      fail_d = 1'b0;
    end else begin
      fail_d = fail_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      idx_q  <= '0;
      base_q <= '0;
      addr_q <= '0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      base_q <= base_d;
      addr_q <= addr_d;
      fail_q <= fail_d;
    end
  end

  assign busy    = (st_q != SEQ_IDLE);
  assign in_prog = (st_q == SEQ_REQ);
  assign idx_o   = idx_q;
  assign addr_o  = addr_q;
  assign fail_o  = fail_q;
endmodule

// File: rtl/mwprog_seq.sv
module mwprog_seq #(
  parameter int NWORDS = 4,
  parameter int DW     = 32,
  parameter int AW     = 32,
  parameter int ALIGN  = 3,
  localparam int IW    = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_sel,
  input  logic [DW-1:0]     wr_data,
  input  logic [IW-1:0]     rd_sel,
  output logic [DW-1:0]     rd_data,
  output logic [DW-1:0]     sw_data,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  input  logic              fail_clr,
  output logic              busy,
  output logic              in_prog,
  output logic [NWORDS-1:0] pend,
  output logic [AW-1:0]     prog_addr,
  output logic              fail,
  output logic              fl_req,
  output logic [AW-1:0]     fl_addr,
  output logic [DW-1:0]     fl_data,
  input  logic              fl_ack,
  input  logic              fl_err
);
  logic                      rst_n_int;
  logic [NWORDS-1:0][DW-1:0] words;
  logic [NWORDS-1:0]         clr_vec;
  logic [IW-1:0]             cur_idx;

  mwprog_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  mwprog_regs #(.NWORDS(NWORDS), .DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .lock    (busy),
    .clr_vec (clr_vec),
    .words_o (words),
    .pend_o  (pend)
  );

  mwprog_fsm #(.NWORDS(NWORDS), .AW(AW), .ALIGN(ALIGN)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .start      (start),
    .start_addr (start_addr),
    .fail_clr   (fail_clr),
    .pend       (pend),
    .fl_ack     (fl_ack),
    .fl_err     (fl_err),
    .busy       (busy),
    .in_prog    (in_prog),
    .idx_o      (cur_idx),
    .addr_o     (prog_addr),
    .clr_vec    (clr_vec),
    .fail_o     (fail)
  );

  assign rd_data = words[rd_sel];
  assign sw_data = words[0];
  assign fl_req  = in_prog;
  assign fl_addr = prog_addr;
  assign fl_data = words[cur_idx];
endmodule

// File: rtl/mwprog_seq_chk.sv
module mwprog_seq_chk #(
  parameter int NWORDS = 4,
  parameter int DW     = 32,
  parameter int AW     = 32,
  parameter int ALIGN  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [AW-1:0]     start_addr,
  input logic              busy,
  input logic [NWORDS-1:0] pend,
  input logic              fail,
  input logic              fl_req,
  input logic [AW-1:0]     fl_addr,
  input logic [DW-1:0]     fl_data,
  input logic              fl_ack,
  input logic              fl_err
);
  localparam logic [AW-1:0] LOW_MASK = AW'((64'd1 << ALIGN) - 64'd1);

  assert_req_in_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |-> busy);

  assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && !fl_ack) |=> (fl_req && $stable(fl_addr) && $stable(fl_data)));

  assert_word_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |-> (fl_addr[1:0] == 2'b00));

  assert_commit_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && fl_ack && !fl_err) |=> ($countones(pend) == $countones($past(pend)) - 1));

  assert_error_stops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_req && fl_ack && fl_err) |=> (fail && !busy && pend == $past(pend)));

  assert_locked_pend_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fl_ack) |=> $stable(pend));

  assert_misaligned_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && ((start_addr & LOW_MASK) != '0)) |=> (fail && !busy));
endmodule

bind mwprog_seq mwprog_seq_chk #(
  .NWORDS(NWORDS), .DW(DW), .AW(AW), .ALIGN(ALIGN)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .start_addr (start_addr),
  .busy       (busy),
  .pend       (pend),
  .fail       (fail),
  .fl_req     (fl_req),
  .fl_addr    (fl_addr),
  .fl_data    (fl_data),
  .fl_ack     (fl_ack),
  .fl_err     (fl_err)
);

// File: tb/mwprog_seq_tb.sv
`timescale 1ns/1ps
module mwprog_seq_tb_top;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic [1:0]  rd_sel;
  logic [31:0] rd_data;
  logic [31:0] sw_data;
  logic        start;
  logic [31:0] start_addr;
  logic        fail_clr;
  logic        busy;
  logic        in_prog;
  logic [3:0]  pend;
  logic [31:0] prog_addr;
  logic        fail;
  logic        fl_req;
  logic [31:0] fl_addr;
  logic [31:0] fl_data;
  logic        fl_ack;
  logic        fl_err;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int lat = 0;
  int wcnt = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [31:0] log_q[$];

  // behavioural reference model state
  int          m_mode;   // 0 idle, 1 looking for next word, 2 waiting on flash
  int          m_pos;
  logic [31:0] m_base, m_addr;
  logic [31:0] m_word[4];
  logic [3:0]  m_pend;
  logic        m_fail;
  logic        m_s1, m_s2;

  mwprog_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .sw_data(sw_data), .start(start),
    .start_addr(start_addr), .fail_clr(fail_clr), .busy(busy), .in_prog(in_prog),
    .pend(pend), .prog_addr(prog_addr), .fail(fail), .fl_req(fl_req),
    .fl_addr(fl_addr), .fl_data(fl_data), .fl_ack(fl_ack), .fl_err(fl_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    m_mode = 0; m_pos = 0; m_base = '0; m_addr = '0; m_pend = '0; m_fail = 1'b0;
    for (int k = 0; k < 4; k++) m_word[k] = '0;
  endtask

  // reference model: advance on every edge, compare shortly after
  always @(posedge clk) begin
    bit hit_fail;
    cycles++;
    if (!rst_n) begin
      model_clear(); m_s1 = 1'b0; m_s2 = 1'b0;
    end else begin
      if (!m_s2) begin
        model_clear();
      end else begin
        hit_fail = 1'b0;
        if (m_mode == 0) begin
          if (wr_en) begin
            m_word[wr_sel] = wr_data;
            m_pend[wr_sel] = 1'b1;
          end
          if (start) begin
            if (start_addr % 8 == 0) begin
              m_mode = 1; m_pos = 0; m_base = start_addr; m_addr = start_addr;
            end else hit_fail = 1'b1;
          end
        end else if (m_mode == 1) begin
          if (m_pend[m_pos]) begin
            m_mode = 2; m_addr = m_base + 32'(4 * m_pos);
          end else if (m_pos == 3) m_mode = 0;
          else m_pos++;
        end else if (fl_ack) begin
          if (fl_err) begin
            hit_fail = 1'b1; m_mode = 0;
          end else begin
            m_pend[m_pos] = 1'b0;
            if (m_pos == 3) m_mode = 0;
            else begin m_pos++; m_mode = 1; end
          end
        end
        if (hit_fail) m_fail = 1'b1;
        else if (fail_clr) m_fail = 1'b0;
      end
      m_s2 = m_s1; m_s1 = 1'b1;
    end
    #1;
    check("R4 busy", 32'(busy), 32'(m_mode != 0));
    check("R6 in_prog", 32'(in_prog), 32'(m_mode == 2));
    check("R6 fl_req", 32'(fl_req), 32'(m_mode == 2));
    check("R7 pend", 32'(pend), 32'(m_pend));
    check("R8 prog_addr", prog_addr, m_addr);
    check("R12 fail", 32'(fail), 32'(m_fail));
    check("R3 sw_data", sw_data, m_word[0]);
    check("R2 rd_data", rd_data, m_word[rd_sel]);
    if (m_mode == 2) begin
      check("R5 fl_addr", fl_addr, m_addr);
      check("R5 fl_data", fl_data, m_word[m_pos]);
    end
  end

  // flash responder
  always @(negedge clk) begin
    if (fl_req) begin
      if (wcnt >= lat) begin
        fl_ack <= 1'b1;
        fl_err <= (fl_addr == err_addr);
        if (fl_addr != err_addr) log_q.push_back(fl_addr);
        wcnt = 0;
      end else begin
        fl_ack <= 1'b0; fl_err <= 1'b0; wcnt++;
      end
    end else begin
      fl_ack <= 1'b0; fl_err <= 1'b0; wcnt = 0;
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles > 50000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic put(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic go(input logic [31:0] a);
    @(negedge clk); start = 1'b1; start_addr = a;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
  endtask

  task automatic check_log(input string tag, input logic [31:0] exp[$]);
    check({tag, " count"}, 32'(log_q.size()), 32'(exp.size()));
    for (int k = 0; k < exp.size() && k < log_q.size(); k++) check(tag, log_q[k], exp[k]);
    log_q.delete();
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
    start = 1'b0; start_addr = '0; fail_clr = 1'b0; fl_ack = 1'b0; fl_err = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    check("R1 busy", 32'(busy), 0);
    check("R1 pend", 32'(pend), 0);
    check("R1 fail", 32'(fail), 0);
    check("R1 prog_addr", prog_addr, 0);
    check("R1 fl_req", 32'(fl_req), 0);

    // R2 / R3 buffer writes and read-back
    put(2'd0, 32'hA0A0_0001); put(2'd1, 32'hB1B1_0002);
    put(2'd2, 32'hC2C2_0003); put(2'd3, 32'hD3D3_0004);
    for (int k = 0; k < 4; k++) begin
      rd_sel = 2'(k); @(negedge clk);
      check("R2 readback", rd_data, m_word[k]);
    end
    check("R2 pend all", 32'(pend), 32'hF);
    check("R3 shared word", sw_data, 32'hA0A0_0001);

    // R5 / R7 / R8 full run
    lat = 1;
    go(32'h0000_0100);
    check("R4 busy raised", 32'(busy), 1);
    wait_done();
    check_log("R5 full order", '{32'h100, 32'h104, 32'h108, 32'h10C});
    check("R7 all committed", 32'(pend), 0);
    check("R8 final addr", prog_addr, 32'h10C);

    // R5 sparse run, R11 ignored write and start while busy
    put(2'd1, 32'h1111_1111); put(2'd3, 32'h3333_3333);
    lat = 3;
    go(32'h0000_2008);
    @(negedge clk); wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'hDEAD_BEEF; start = 1'b1; start_addr = 32'h40;
    @(negedge clk); wr_en = 1'b0; start = 1'b0;
    wait_done();
    check_log("R5 sparse order", '{32'h200C, 32'h2014});
    rd_sel = 2'd2; @(negedge clk);
    check("R11 write ignored", rd_data, 32'hC2C2_0003);
    check("R11 pend untouched", 32'(pend), 0);
    check("R8 sparse final", prog_addr, 32'h2014);

    // R8 empty run
    go(32'h0000_0040);
    wait_done();
    check_log("R5 empty run", '{});
    check("R8 empty keeps base", prog_addr, 32'h40);

    // R10 misaligned start, R12 clear and priority
    put(2'd0, 32'h5555_0000);
    go(32'h0000_0044);
    check("R10 fail set", 32'(fail), 1);
    check("R10 no run", 32'(busy), 0);
    check("R10 pend kept", 32'(pend), 32'h1);
    @(negedge clk); start = 1'b1; start_addr = 32'h2; fail_clr = 1'b1;
    @(negedge clk); start = 1'b0; fail_clr = 1'b0;
    check("R12 set wins", 32'(fail), 1);
    @(negedge clk); fail_clr = 1'b1;
    @(negedge clk); fail_clr = 1'b0;
    check("R12 cleared", 32'(fail), 0);

    // R9 verify error mid-run, then resume
    put(2'd1, 32'h6666_0001); put(2'd2, 32'h7777_0002); put(2'd3, 32'h8888_0003);
    lat = 2; err_addr = 32'h0000_3004;
    go(32'h0000_3000);
    wait_done();
    check_log("R9 before error", '{32'h3000});
    check("R9 fail", 32'(fail), 1);
    check("R9 pend tail", 32'(pend), 32'hE);
    check("R9 idle", 32'(busy), 0);
    @(negedge clk); fail_clr = 1'b1;
    @(negedge clk); fail_clr = 1'b0;
    err_addr = 32'hFFFF_FFFF; lat = 0;
    go(32'h0000_3000);
    wait_done();
    check_log("R9 resumed", '{32'h3004, 32'h3008, 32'h300C});
    check("R7 resumed clear", 32'(pend), 0);
    check("R9 fail stays clear", 32'(fail), 0);

    idle(3);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule